// File: doc/BRIEF.md
# Register Write-Protection Unlock Sequencer

This block sits on the write path of a small memory-mapped peripheral and keeps its configuration registers closed until software has written an exact chain of seven key words. Each key is a specific byte value at a specific word offset, and the seven keys must arrive in a fixed order. The block watches a simple register bus made of valid, write, address and write data. It reports how far the chain has progressed and raises a sticky unlocked flag once the chain is complete.

A wrong write inside the key window sends the chain back to its start. If that wrong write is itself a correct first key, it counts as the first step. Writes outside the key window leave the chain where it is.

The flag gates the write strobes of two protected registers: a control register and a debounce register. The debounce register carries a 3-bit field. The protected registers themselves live downstream.

Top module: `wpu_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `unlocked` is 0, `step_idx` is 0, `prot_we` is 0 and `dbnc_field` is 0.
- R2: The key chain is byte 0xC6 at offset 0x04, 0x9A at 0x08, 0x59 at 0x0C, 0xA3 at 0x10, 0x57 at 0x14, 0x67 at 0x18 and 0xD2 at 0x1C, in that order. After the seventh correct write, `unlocked` is 1 from the clock edge that samples that write, and not earlier.
- R3: A write to an address in 0x04..0x1C (aligned or not) that does not match the expected step sets `step_idx` to 0, unless R4 applies.
- R4: A mismatching write that equals the first key (0xC6 at 0x04) sets `step_idx` to 1.
- R5: Writes to addresses below 0x04 or above 0x1C, and bus cycles with valid low or write low, leave `step_idx` unchanged.
- R6: Once set, `unlocked` stays 1 until reset, whatever the bus does afterwards.
- R7: `prot_we[0]` is 1 exactly when a write to offset 0x20 occurs while unlocked. `prot_we[1]` is 1 exactly when a write to offset 0x2C occurs while unlocked. Both strobes are combinational in the cycle of the write.
- R8: `dbnc_field` equals write data bits 2:0 when `prot_we[1]` is 1, and is 0 otherwise.
- R9: A key matches only when the whole data word equals the zero-extended key byte, so any nonzero upper data bit makes the write a mismatch.
- R10: `step_idx` counts the correct steps taken so far (0 to 6) and reads 7 once unlocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus cycle valid |
| bus_write | input | 1 | Bus cycle is a write |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_wdata | input | DATA_W (32) | Write data |
| unlocked | output | 1 | Sticky unlock flag |
| step_idx | output | 3 | Key steps completed, 7 when unlocked |
| prot_we | output | 2 | Permitted write strobes: bit 0 control (0x20), bit 1 debounce (0x2C) |
| dbnc_field | output | 3 | Debounce field value for a permitted debounce write |

## Verification
The bench builds the block with its defaults: an 8-bit address and a 32-bit data word. With an 8-bit address, every offset from 0x00 to 0x3F can be swept after each possible chain position. This covers each key offset, the unaligned offsets inside the window, and both protected offsets, all checked against a small arithmetic model of the chain. At every position the bench also applies a wrong byte value at each key offset, a correct byte with a set upper bit, and a replayed first key. The full-width data word makes the upper-bit mismatch case reachable.

// File: rtl/wpu_pkg.sv
package wpu_pkg;
  localparam int NUM_KEYS  = 7;
  localparam int KEY_BASE  = 4;
  localparam int KEY_PITCH = 4;
  localparam int KEY_LAST  = KEY_BASE + KEY_PITCH * (NUM_KEYS - 1);
  localparam int CTRL_OFS  = 32'h20;
  localparam int DBNC_OFS  = 32'h2C;
  localparam int DBNC_W    = 3;
  localparam int STEP_W    = $clog2(NUM_KEYS + 1);

  // Byte offset of key lane idx
  function automatic int key_offset(input int idx);
    return KEY_BASE + KEY_PITCH * idx;
  endfunction

  // Key byte expected at lane idx
  function automatic logic [7:0] key_byte(input int idx);
    case (idx)
      0: return 8'hC6;
      1: return 8'h9A;
      2: return 8'h59;
      3: return 8'hA3;
      4: return 8'h57;
      5: return 8'h67;
      6: return 8'hD2;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/wpu_key_match.sv
module wpu_key_match
  import wpu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STEP_W-1:0] exp_step,
  output logic              in_window,
  output logic              step_hit,
  output logic              first_hit
);
  logic [NUM_KEYS-1:0] lane_hit;

  generate
    for (genvar i = 0; i < NUM_KEYS; i++) begin : g_lane
      assign lane_hit[i] = (addr == ADDR_W'(key_offset(i))) &&
                           (wdata == DATA_W'(key_byte(i)));
    end
  endgenerate

  assign in_window = (addr >= ADDR_W'(KEY_BASE)) && (addr <= ADDR_W'(KEY_LAST));
  assign first_hit = lane_hit[0];

  always_comb begin
    step_hit = 1'b0;
    for (int i = 0; i < NUM_KEYS; i++) begin
      if (exp_step == STEP_W'(i)) step_hit = lane_hit[i];
    end
  end
endmodule

// File: rtl/wpu_seq_ctrl.sv
module wpu_seq_ctrl
  import wpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic              in_window,
  input  logic              step_hit,
  input  logic              first_hit,
  output logic [STEP_W-1:0] step_q,
  output logic              unlocked_q
);
  logic [STEP_W-1:0] step_d;
  logic              unlocked_d;
  logic              key_cycle;

  assign key_cycle = wr_fire && in_window && !unlocked_q;

  always_comb begin
    step_d     = step_q;
    unlocked_d = unlocked_q;
    if (key_cycle) begin
      if (step_hit) begin
        step_d = step_q + STEP_W'(1);
        if (step_q == STEP_W'(NUM_KEYS - 1)) unlocked_d = 1'b1;
      end else if (first_hit) begin
        step_d = STEP_W'(1);
      end else begin
        step_d = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q     <= '0;
      unlocked_q <= 1'b0;
    end else begin
      step_q     <= step_d;
      unlocked_q <= unlocked_d;
    end
  end
endmodule

// File: rtl/wpu_wr_gate.sv
module wpu_wr_gate
  import wpu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              wr_fire,
  input  logic              unlocked,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [1:0]        prot_we,
  output logic [DBNC_W-1:0] dbnc_field
);
  assign prot_we[0] = wr_fire && unlocked && (addr == ADDR_W'(CTRL_OFS));
  assign prot_we[1] = wr_fire && unlocked && (addr == ADDR_W'(DBNC_OFS));
  assign dbnc_field = prot_we[1] ? wdata[DBNC_W-1:0] : '0;
endmodule

// File: rtl/wpu_top.sv
module wpu_top
  import wpu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              unlocked,
  output logic [STEP_W-1:0] step_idx,
  output logic [1:0]        prot_we,
  output logic [DBNC_W-1:0] dbnc_field
);
  logic wr_fire;
  logic in_window;
  logic step_hit;
  logic first_hit;

  assign wr_fire = bus_valid && bus_write;

  wpu_key_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .exp_step  (step_idx),
    .in_window (in_window),
    .step_hit  (step_hit),
    .first_hit (first_hit)
  );

  wpu_seq_ctrl u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_fire    (wr_fire),
    .in_window  (in_window),
    .step_hit   (step_hit),
    .first_hit  (first_hit),
    .step_q     (step_idx),
    .unlocked_q (unlocked)
  );

  wpu_wr_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gate (
    .wr_fire    (wr_fire),
    .unlocked   (unlocked),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .prot_we    (prot_we),
    .dbnc_field (dbnc_field)
  );
endmodule

// File: rtl/wpu_checker.sv
module wpu_checker
  import wpu_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              unlocked,
  input logic [STEP_W-1:0] step_idx,
  input logic [1:0]        prot_we,
  input logic              in_window,
  input logic              step_hit,
  input logic              first_hit
);
  // R1: first cycle out of reset is locked at step 0
  a_r1_reset_state: assert property (@(posedge clk)
    $rose(rst_n) |-> (!unlocked && step_idx == '0));

  // R6: the unlock flag never drops without reset
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked |=> unlocked);

  // R2: unlock only after the final key lane hit
  a_r2_unlock_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && bus_valid && bus_write && in_window && step_hit &&
     step_idx == STEP_W'(NUM_KEYS - 1)) |=> unlocked);

  a_r2_no_early_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && !(bus_valid && bus_write && step_idx == STEP_W'(NUM_KEYS - 1)))
      |=> !unlocked);

  // R3: wrong in-window write that is not a first key clears progress
  a_r3_mismatch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && bus_valid && bus_write && in_window && !step_hit && !first_hit)
      |=> step_idx == '0);

  // R4: wrong write equal to the first key restarts at step 1
  a_r4_restart_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && bus_valid && bus_write && !step_hit && first_hit)
      |=> step_idx == STEP_W'(1));

  // R5: out-of-window traffic leaves progress alone
  a_r5_outside_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_valid && bus_write && in_window)) |=> $stable(step_idx));

  // R7: protected strobes need the unlock flag and a single target
  a_r7_gate_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_we != 2'b00) |-> (unlocked && $onehot0(prot_we)));

  // R10: progress reads 7 exactly when unlocked
  a_r10_step_full: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked |-> step_idx == STEP_W'(NUM_KEYS));
endmodule

bind wpu_top wpu_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .unlocked  (unlocked),
  .step_idx  (step_idx),
  .prot_we   (prot_we),
  .in_window (in_window),
  .step_hit  (step_hit),
  .first_hit (first_hit)
);

// File: tb/tb_wpu_top.sv
module tb_wpu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        unlocked;
  logic [2:0]  step_idx;
  logic [1:0]  prot_we;
  logic [2:0]  dbnc_field;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  wpu_top dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .unlocked(unlocked),
    .step_idx(step_idx), .prot_we(prot_we), .dbnc_field(dbnc_field)
  );

  // independent table of the key chain
  function automatic logic [7:0] kv(input int i);
    logic [7:0] t [7] = '{8'hC6, 8'h9A, 8'h59, 8'hA3, 8'h57, 8'h67, 8'hD2};
    return t[i];
  endfunction

  function automatic int ka(input int i);
    return 4 * (i + 1);
  endfunction

  // reference model of one write while locked
  function automatic int model_next(input int cur, input int a, input logic [31:0] d);
    if (a < 4 || a > 28) return cur;
    if (a == ka(cur) && d == {24'h0, kv(cur)}) return cur + 1;
    if (a == 4 && d == {24'h0, kv(0)}) return 1;
    return 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bus_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one bus cycle; outputs of the registered state sampled at the next negedge
  task automatic bus_cycle(input bit v, input bit w, input int a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = v;
    bus_write = w;
    bus_addr  = 8'(a);
    bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0;
    bus_write = 1'b0;
  endtask

  task automatic walk(input int n);
    for (int i = 0; i < n; i++) bus_cycle(1, 1, ka(i), {24'h0, kv(i)});
  endtask

  initial begin
    do_reset();
    // R1
    check("R1 unlocked", int'(unlocked), 0);
    check("R1 step_idx", int'(step_idx), 0);
    check("R1 prot_we", int'(prot_we), 0);
    check("R1 dbnc_field", int'(dbnc_field), 0);

    // R2: full chain, unlock only at the edge of the 7th write
    for (int i = 0; i < 7; i++) begin
      bus_cycle(1, 1, ka(i), {24'h0, kv(i)});
      check("R2 unlocked timing", int'(unlocked), (i == 6) ? 1 : 0);
      check("R10 step count", int'(step_idx), i + 1);
    end

    // R7/R8: permitted strobes while unlocked
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = 8'h20; bus_wdata = 32'hFFFF_FFF5;
    #1 check("R7 ctrl strobe", int'(prot_we), 1);
    check("R8 no field on ctrl", int'(dbnc_field), 0);
    bus_addr = 8'h2C;
    #1 check("R7 dbnc strobe", int'(prot_we), 2);
    check("R8 field bits", int'(dbnc_field), 5);
    bus_write = 0;
    #1 check("R7 read gives no strobe", int'(prot_we), 0);
    bus_valid = 0;

    // R6: arbitrary traffic after unlock
    for (int a = 0; a < 64; a++) begin
      bus_cycle(1, 1, a, 32'h0);
      check("R6 sticky", int'(unlocked), 1);
    end

    // R3/R4/R5/R9 sweeps after every chain position
    for (int k = 0; k < 7; k++) begin
      for (int a = 0; a < 64; a++) begin
        logic [31:0] d;
        int own;
        own = -1;
        for (int j = 0; j < 7; j++) if (ka(j) == a) own = j;
        d = (own >= 0) ? {24'h0, kv(own)} : 32'h0000_005A;
        do_reset();
        walk(k);
        bus_cycle(1, 1, a, d);
        check((a < 4 || a > 28) ? "R5 outside" : "R3/R4 key sweep",
              int'(step_idx), model_next(k, a, d));
        check("R2 no unlock on sweep", int'(unlocked), (k == 6 && a == 28) ? 1 : 0);
      end
      for (int j = 0; j < 7; j++) begin
        do_reset();
        walk(k);
        bus_cycle(1, 1, ka(j), {24'h0, kv(j) ^ 8'h01});
        check("R3 wrong byte", int'(step_idx), 0);
      end
      // R9: correct byte with upper bit set
      do_reset();
      walk(k);
      bus_cycle(1, 1, ka(k), {24'h01, kv(k)});
      check("R9 upper bits", int'(step_idx), 0);
      // R4: replayed first key
      if (k > 1) begin
        do_reset();
        walk(k);
        bus_cycle(1, 1, 4, {24'h0, kv(0)});
        check("R4 restart", int'(step_idx), 1);
      end
      // R5: read and idle cycles with key data
      do_reset();
      walk(k);
      bus_cycle(1, 0, ka(k), {24'h0, kv(k)});
      bus_cycle(0, 1, ka(k), {24'h0, kv(k)});
      check("R5 read/idle", int'(step_idx), k);
      // R7: protected writes refused while locked
      @(negedge clk);
      bus_valid = 1; bus_write = 1; bus_addr = 8'h2C; bus_wdata = 32'h7;
      #1 check("R7 locked strobe", int'(prot_we), 0);
      check("R8 locked field", int'(dbnc_field), 0);
      bus_valid = 0; bus_write = 0;
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule